// File: doc/BRIEF.md
# Processor Idle Clock Gate

This block stops and restarts the clock of a processor core to give an idle mode. Software asks for the stop by writing a disable command. The block then lets the instruction in flight retire before it closes the gate. The gate reopens by itself when an enabled fast or normal interrupt request arrives, or when reset is applied. Software takes no part in the wake-up.

The gated clock comes from a free-running clock, ANDed with an enable that is held in a latch. The latch is transparent only while the clock is low, so the gated clock cannot be cut short or glitch. A status output reports whether the core clock is running. Enabled interrupt requests pass through a synchronizer of `WAKE_SYNC` stages before they can wake the core. Only the core clock is gated, so the free-running clock that the rest of the system bus uses is not affected.

Top module: `pidle_clk_gate`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, `clk_on_o` and `core_clk_en_o` are both 1.
- R2: A disable write (`dis_wr_i`=1) in a cycle where `instr_done_i`=1 and no wake is effective stops the clock at that rising edge. `clk_on_o` and `core_clk_en_o` read 0 in the following low phase.
- R3: A disable write made while `instr_done_i`=0 keeps the clock running for as many cycles as `instr_done_i` stays 0. The clock stops at the first rising edge that samples `instr_done_i`=1.
- R4: A fast request bit that is 1 while its mask bit is 1 becomes effective at the rising edge that comes `WAKE_SYNC` edges after the edge that samples it (the default is 2). At that edge the clock restarts, or a pending stop is cancelled.
- R5: A normal request bit that is 1 while its mask bit is 1 wakes the core with the same timing as R4.
- R6: A request bit whose mask bit is 0 never wakes the core. An idle core stays idle as long as no enabled request is effective.
- R7: Asserting reset while the core is idle sets `clk_on_o` and `core_clk_en_o` to 1 at once, without waiting for a clock edge.
- R8: If a wake is effective at the same rising edge that samples a disable write, the wake wins and the clock keeps running.
- R9: `core_clk_o` is 0 whenever `clk_i` is low. During each high phase it equals the enable value held through the preceding low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dis_wr_i | input | 1 | One-cycle strobe: write of the disable command |
| instr_done_i | input | 1 | Core reports that the current instruction retires this cycle |
| fast_req_i | input | N_FAST | Fast interrupt request lines |
| fast_mask_i | input | N_FAST | Enable mask for the fast requests |
| norm_req_i | input | N_NORM | Normal interrupt request lines |
| norm_mask_i | input | N_NORM | Enable mask for the normal requests |
| core_clk_o | output | 1 | Gated processor clock |
| core_clk_en_o | output | 1 | Latched gate enable (changes only while clk_i is low) |
| clk_on_o | output | 1 | Status: 1 while the processor clock is running |

## Verification
A stop caused by a disable write or by a retiring instruction shows up one rising edge later. A wake shows up `WAKE_SYNC`+1 rising edges after the edge that first samples the enabled request. A reset acts at once. The bench drives inputs just after each falling edge. It moves its reference model at the rising edge, through a queue that delays wakes by the synchronizer depth. It checks the gated clock just after the rising edge and the enable and status just after the falling edge, so every result is compared in the half-cycle when it is due.

// File: rtl/pidle_pkg.sv
package pidle_pkg;

   typedef enum logic [1:0] {
      PG_RUN   = 2'd0,
      PG_DRAIN = 2'd1,
      PG_IDLE  = 2'd2
   } pg_state_e;

   localparam int unsigned PG_MAX_SYNC = 4;

endpackage

// File: rtl/pidle_wake.sv
module pidle_wake #(
   parameter int unsigned N_FAST    = 1,
   parameter int unsigned N_NORM    = 8,
   parameter int unsigned WAKE_SYNC = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_FAST-1:0] fast_req_i,
   input  logic [N_FAST-1:0] fast_mask_i,
   input  logic [N_NORM-1:0] norm_req_i,
   input  logic [N_NORM-1:0] norm_mask_i,
   output logic              wake_o
);

   logic fast_hit;
   logic norm_hit;
   logic raw_wake;

   assign fast_hit = |(fast_req_i & fast_mask_i);
   assign norm_hit = |(norm_req_i & norm_mask_i);
   assign raw_wake = fast_hit | norm_hit;

   generate
      if (WAKE_SYNC == 0) begin : g_direct
         assign wake_o = raw_wake;
      end else if (WAKE_SYNC == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q <= 1'b0;
            else         stage_q <= raw_wake;
         end
         assign wake_o = stage_q;
      end else begin : g_chain
         logic [WAKE_SYNC-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[WAKE_SYNC-2:0], raw_wake};
         end
         assign wake_o = chain_q[WAKE_SYNC-1];
      end
   endgenerate

endmodule

// File: rtl/pidle_ctrl.sv
module pidle_ctrl
   import pidle_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic dis_wr_i,
   input  logic instr_done_i,
   input  logic wake_i,
   output logic run_o
);

   pg_state_e state_q;
   pg_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PG_RUN: begin
            if (dis_wr_i && !wake_i) begin
               state_d = instr_done_i ? PG_IDLE : PG_DRAIN;
            end
         end
         PG_DRAIN: begin
            if (wake_i)            state_d = PG_RUN;
            else if (instr_done_i) state_d = PG_IDLE;
         end
         PG_IDLE: begin
            if (wake_i) state_d = PG_RUN;
         end
         default: state_d = PG_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= PG_RUN;
      else         state_q <= state_d;
   end

   assign run_o = (state_q != PG_IDLE);

endmodule

// File: rtl/pidle_cgate.sv
module pidle_cgate #(
   parameter bit USE_LATCH = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic en_held_o,
   output logic gclk_o
);

   logic held;

   generate
      if (USE_LATCH) begin : g_latch
         always_latch begin
            if (!rst_ni)     held = 1'b1;
            else if (!clk_i) held = en_i;
         end
      end else begin : g_negflop
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) held <= 1'b1;
            else         held <= en_i;
         end
      end
   endgenerate

   assign en_held_o = held;
   assign gclk_o    = clk_i & held;

endmodule

// File: rtl/pidle_clk_gate.sv
module pidle_clk_gate
   import pidle_pkg::*;
#(
   parameter int unsigned N_FAST    = 1,
   parameter int unsigned N_NORM    = 8,
   parameter int unsigned WAKE_SYNC = 2,
   parameter bit          USE_LATCH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dis_wr_i,
   input  logic              instr_done_i,
   input  logic [N_FAST-1:0] fast_req_i,
   input  logic [N_FAST-1:0] fast_mask_i,
   input  logic [N_NORM-1:0] norm_req_i,
   input  logic [N_NORM-1:0] norm_mask_i,
   output logic              core_clk_o,
   output logic              core_clk_en_o,
   output logic              clk_on_o
);

   generate
      if (N_FAST < 1) begin : g_bad_fast
         $error("pidle_clk_gate: N_FAST must be at least 1");
      end
      if (N_NORM < 1) begin : g_bad_norm
         $error("pidle_clk_gate: N_NORM must be at least 1");
      end
      if (WAKE_SYNC > PG_MAX_SYNC) begin : g_bad_sync
         $error("pidle_clk_gate: WAKE_SYNC exceeds PG_MAX_SYNC");
      end
   endgenerate

   logic wake;
   logic run;

   pidle_wake #(
      .N_FAST   (N_FAST),
      .N_NORM   (N_NORM),
      .WAKE_SYNC(WAKE_SYNC)
   ) u_wake (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fast_req_i (fast_req_i),
      .fast_mask_i(fast_mask_i),
      .norm_req_i (norm_req_i),
      .norm_mask_i(norm_mask_i),
      .wake_o     (wake)
   );

   pidle_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dis_wr_i    (dis_wr_i),
      .instr_done_i(instr_done_i),
      .wake_i      (wake),
      .run_o       (run)
   );

   pidle_cgate #(
      .USE_LATCH(USE_LATCH)
   ) u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (run),
      .en_held_o(core_clk_en_o),
      .gclk_o   (core_clk_o)
   );

   assign clk_on_o = run;

endmodule

// File: rtl/pidle_clk_gate_chk.sv
module pidle_clk_gate_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic dis_wr_i,
   input logic instr_done_i,
   input logic wake_i,
   input logic clk_on_o,
   input logic core_clk_en_o
);

   // R1
   reset_on_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (clk_on_o && core_clk_en_o));

   // R3
   defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_on_o && !instr_done_i) |=> clk_on_o);

   // R2
   stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_on_o && dis_wr_i && instr_done_i && !wake_i) |=> !clk_on_o);

   // R4 R5 R8
   wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_i |=> clk_on_o);

   // R6
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_on_o && !wake_i) |=> !clk_on_o);

   // R9
   gate_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_clk_en_o == clk_on_o);

endmodule

bind pidle_clk_gate pidle_clk_gate_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .dis_wr_i     (dis_wr_i),
   .instr_done_i (instr_done_i),
   .wake_i       (wake),
   .clk_on_o     (clk_on_o),
   .core_clk_en_o(core_clk_en_o)
);

// File: tb/sim_pidle_clk_gate.sv
`timescale 1ns/1ps
module sim_pidle_clk_gate;

   localparam int CLK_PERIOD = 10;
   localparam int NF = 1;
   localparam int NN = 8;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dis_wr = 1'b0;
   logic done = 1'b0;
   logic [NF-1:0] freq = '0, fmask = '0;
   logic [NN-1:0] nreq = '0, nmask = '0;
   logic gclk, gen, on;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // model state: 0 run, 1 draining, 2 idle
   int m_st;
   bit m_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pidle_clk_gate #(.N_FAST(NF), .N_NORM(NN), .WAKE_SYNC(SYNC)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .dis_wr_i(dis_wr), .instr_done_i(done),
      .fast_req_i(freq), .fast_mask_i(fmask),
      .norm_req_i(nreq), .norm_mask_i(nmask),
      .core_clk_o(gclk), .core_clk_en_o(gen), .clk_on_o(on));

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_st = 0;
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b0);
   endtask

   task automatic step(input string tag, input logic dw, input logic dn,
                       input logic [NF-1:0] fr, input logic [NF-1:0] fm,
                       input logic [NN-1:0] nr, input logic [NN-1:0] nm);
      bit raw, w;
      logic en_before;
      dis_wr = dw; done = dn; freq = fr; fmask = fm; nreq = nr; nmask = nm;
      raw = (|(fr & fm)) | (|(nr & nm));
      en_before = (m_st != 2);
      @(posedge clk); #1;
      chk("R9", "gated clock high phase", gclk, en_before);
      if (SYNC == 0) w = raw;
      else begin
         w = m_q.pop_front();
         m_q.push_back(raw);
      end
      case (m_st)
         0: if (dw && !w) m_st = dn ? 2 : 1;
         1: if (w) m_st = 0; else if (dn) m_st = 2;
         default: if (w) m_st = 0;
      endcase
      @(negedge clk); #1;
      chk("R9", "gated clock low phase", gclk, 1'b0);
      chk(tag, "status", on, m_st != 2);
      chk(tag, "enable", gen, m_st != 2);
   endtask

   task automatic quiet(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, '0, '0, '0, '0);
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      model_reset();
      rst_n = 1'b0;
      #2;
      chk("R1", "status in reset", on, 1'b1);
      chk("R1", "enable in reset", gen, 1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      rst_n = 1'b1;
      quiet("R1", 2);

      // immediate stop with retiring instruction
      step("R2", 1, 1, '0, '0, '0, '0);
      // masked requests while idle
      for (int i = 0; i < 6; i++) step("R6", 0, i[0], 1'b1, 1'b0, 8'hFF, 8'h00);
      // enabled fast request wakes
      step("R4", 0, 0, 1'b1, 1'b1, '0, '0);
      quiet("R4", 4);
      // deferred stop
      step("R3", 1, 0, '0, '0, '0, '0);
      quiet("R3", 3);
      step("R3", 0, 1, '0, '0, '0, '0);
      quiet("R3", 2);
      // normal request wakes from idle
      step("R5", 0, 0, '0, '0, 8'h10, 8'h10);
      quiet("R5", 3);
      // pending stop cancelled by normal request
      step("R5", 1, 0, '0, '0, 8'h04, 8'h0C);
      quiet("R5", 3);
      step("R5", 0, 1, '0, '0, '0, '0);
      // wake effective at the disable write edge
      step("R8", 0, 0, '0, '0, 8'h80, 8'h80);
      step("R8", 0, 0, '0, '0, '0, '0);
      step("R8", 1, 1, '0, '0, '0, '0);
      quiet("R8", 3);
      // reset while idle
      step("R7", 1, 1, '0, '0, '0, '0);
      quiet("R7", 1);
      rst_n = 1'b0;
      #1;
      chk("R7", "status on reset", on, 1'b1);
      chk("R7", "enable on reset", gen, 1'b1);
      model_reset();
      @(negedge clk); #1;
      rst_n = 1'b1;
      quiet("R1", 1);
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         int r;
         r = $urandom;
         step("R6", r[2:0] == 0, r[4:3] == 0, r[5], r[6], {r[12:10], r[9:5]},
              (r[20:18] == 0) ? 8'h00 : {r[17:13], r[15:13]});
      end
      quiet("R6", 4);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule